// File: doc/BRIEF.md
# Light-sensor register target on a two-wire bus

This block is a two-wire (I2C) target that exposes a small register bank of a light-sensing front end to a host controller. The controller addresses the target with a fixed 7-bit address. The first byte written after the address is a command byte. It either loads a 5-bit register pointer and picks how that pointer moves, or triggers a special function. The only special function that does anything clears the pending interrupt. Later data bytes are written to, or read from, the register that the pointer selects. A read that comes with no command uses the pointer left by the last command. The controller can also write a command, issue a repeated start, and read straight back.

The bank holds a row of writable configuration bytes, which the surrounding logic sees on `cfg_o`. It also holds a fixed identity byte, a status byte built from two live flags, and two 16-bit conversion results. Each result is read as a low byte and then a high byte. Reading a low byte captures the matching high byte in a shadow latch, so a conversion that finishes between the two reads cannot tear the value. The bus lines are oversampled by the system clock. SDA is driven only as an open-drain pull-down enable.

Top module: `lux_reg_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper 7 bits equal `TARGET_ADDR` (default 0x39). On a mismatch it NACKs and does not drive SDA for the rest of that transaction, so later bytes are also not acknowledged. Every write byte of a matched transaction is acknowledged.
- R2: The first byte of a write with bit 7 set is a command. Bits 6:5 give the type: 00 selects repeated mode, 01 selects auto-increment mode, 10 is reserved, and 11 is a special function. For types 00 and 01, bits 4:0 load the pointer.
- R3: In auto-increment mode, every data byte read or written advances the pointer by one, and the pointer wraps from 0x1F to 0x00. In repeated mode, every access uses the same register.
- R4: A command of type 11 with bits 4:0 = 00110 produces exactly one single-cycle pulse on `irq_clear_o`. Type 11 with any other code, and type 10, cause no pulse and leave the pointer and the mode unchanged.
- R5: When the first byte of a write has bit 7 clear, it is written as data at the stored pointer.
- R6: A read with no preceding command starts at the stored pointer. The combined format (command write, repeated start, read) is supported.
- R7: Reading 0x14 captures bits 15:8 of channel 0 into a shadow byte, and reading 0x16 does the same for channel 1. Reads of 0x15 and 0x17 return the shadow byte, even if the channel input has changed since the capture.
- R8: Address 0x12 returns `ID_VALUE` (default 0x34). Address 0x13 returns the interrupt flag in bit 4 and the valid flag in bit 0, with all other bits 0.
- R9: Addresses 0x00 to 0x0F are writable, reset to 0x00, and read back. Byte k appears on `cfg_o[8k+7:8k]`. Writes to 0x10–0x1F are acknowledged but have no effect. Reads of 0x10, 0x11 and 0x18–0x1F return 0x00.
- R10: After the controller NACKs a read byte, the target releases SDA before the stop condition. A stop condition always releases SDA. After reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| ch0_data_i | input | 16 | Channel 0 conversion result |
| ch1_data_i | input | 16 | Channel 1 conversion result |
| irq_flag_i | input | 1 | Interrupt pending flag for the status byte |
| valid_flag_i | input | 1 | Conversion valid flag for the status byte |
| irq_clear_o | output | 1 | Single-cycle interrupt clear pulse |
| cfg_o | output | 128 | Writable configuration bytes, byte k at bits 8k+7:8k |

## Verification
The hardest case to reach from the ports is a torn 16-bit read. It needs a channel input to change after the low byte has been captured but before the high byte is read. The stimulus reads the low byte in one transaction, changes both channel inputs, and then reads the high byte with a fresh command. It checks that the old high byte comes back, while the low byte of the other channel already shows the new value. The quiet paths are confirmed by reading back the pointer afterwards: the reserved command type, the no-action special code, and writes to read-only or unimplemented addresses.

// File: rtl/lux_i2c_pkg.sv
package lux_i2c_pkg;

    typedef enum logic [1:0] {
        XFER_REPEAT  = 2'b00,
        XFER_AUTO    = 2'b01,
        XFER_RSVD    = 2'b10,
        XFER_SPECIAL = 2'b11
    } xfer_e;

    typedef struct packed {
        logic       is_cmd;
        xfer_e      kind;
        logic [4:0] field;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK
    } bus_state_e;

    localparam logic [4:0] SF_INT_CLR = 5'b00110;
    localparam logic [4:0] A_ID       = 5'h12;
    localparam logic [4:0] A_STAT     = 5'h13;
    localparam logic [4:0] A_C0L      = 5'h14;
    localparam logic [4:0] A_C0H      = 5'h15;
    localparam logic [4:0] A_C1L      = 5'h16;
    localparam logic [4:0] A_C1H      = 5'h17;

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.is_cmd = b[7];
        c.kind   = xfer_e'(b[6:5]);
        c.field  = b[4:0];
        return c;
    endfunction

    function automatic logic [7:0] status_byte(input logic irq, input logic valid);
        return {3'b000, irq, 3'b000, valid};
    endfunction

endpackage

// File: rtl/lux_bus_sense.sv
module lux_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_q;
    logic [SYNC_STAGES-1:0] sda_q;
    logic scl_d, sda_d, scl_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_i;
                    sda_q <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
                    sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_q[SYNC_STAGES-1];
    assign sda_s = sda_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/lux_byte_engine.sv
module lux_byte_engine
    import lux_i2c_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'h39
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    output logic       sda_oe,
    output logic       wr_pulse,
    output logic [7:0] wr_byte,
    output logic       wr_first,
    output logic       rd_pulse,
    input  logic [7:0] rd_byte
);
    bus_state_e state;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic       rw, first, m_ack;

    assign rd_pulse = scl_fall & ~start_det & ~stop_det &
                      (((state == ST_AACK) & rw) | ((state == ST_RACK) & m_ack));
    assign wr_byte  = shreg;
    assign wr_first = first;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            shreg    <= '0;
            rw       <= 1'b0;
            first    <= 1'b0;
            m_ack    <= 1'b0;
            sda_oe   <= 1'b0;
            wr_pulse <= 1'b0;
        end else begin
            wr_pulse <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (shreg[7:1] == TARGET_ADDR) begin
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                                state  <= ST_AACK;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                shreg  <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                first  <= 1'b1;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            wr_pulse <= 1'b1;
                            sda_oe   <= 1'b1;
                            state    <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            first  <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (m_ack) begin
                                shreg  <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                state  <= ST_RD;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

endmodule

// File: rtl/lux_reg_bank.sv
module lux_reg_bank
    import lux_i2c_pkg::*;
#(
    parameter int         NUM_CFG  = 16,
    parameter logic [7:0] ID_VALUE = 8'h34
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_pulse,
    input  logic [7:0]           wr_byte,
    input  logic                 wr_first,
    input  logic                 rd_pulse,
    output logic [7:0]           rd_byte,
    input  logic [15:0]          ch0_data,
    input  logic [15:0]          ch1_data,
    input  logic                 irq_flag,
    input  logic                 valid_flag,
    output logic [NUM_CFG*8-1:0] cfg_o,
    output logic                 irq_clear_o
);
    logic [4:0] ptr;
    logic       auto_mode;
    logic [7:0] shadow0, shadow1;
    logic [7:0] cfg [NUM_CFG];
    cmd_t       cmd;
    logic       is_cmd, data_wr;

    assign cmd     = decode_cmd(wr_byte);
    assign is_cmd  = wr_first & cmd.is_cmd;
    assign data_wr = wr_pulse & ~is_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr         <= '0;
            auto_mode   <= 1'b0;
            shadow0     <= '0;
            shadow1     <= '0;
            irq_clear_o <= 1'b0;
        end else begin
            irq_clear_o <= 1'b0;
            if (wr_pulse && is_cmd) begin
                case (cmd.kind)
                    XFER_REPEAT, XFER_AUTO: begin
                        ptr       <= cmd.field;
                        auto_mode <= (cmd.kind == XFER_AUTO);
                    end
                    XFER_SPECIAL: begin
                        if (cmd.field == SF_INT_CLR)
                            irq_clear_o <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (data_wr && auto_mode) begin
                ptr <= ptr + 5'd1;
            end
            if (rd_pulse) begin
                if (auto_mode)
                    ptr <= ptr + 5'd1;
                if (ptr == A_C0L)
                    shadow0 <= ch0_data[15:8];
                if (ptr == A_C1L)
                    shadow1 <= ch1_data[15:8];
            end
        end
    end

    generate
        for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
            always_ff @(posedge clk) begin
                if (rst)
                    cfg[k] <= '0;
                else if (data_wr && ptr == 5'(k))
                    cfg[k] <= wr_byte;
            end
            assign cfg_o[k*8 +: 8] = cfg[k];
        end
    endgenerate

    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < NUM_CFG; k++)
            if (ptr == 5'(k))
                rd_byte = cfg[k];
        case (ptr)
            A_ID:    rd_byte = ID_VALUE;
            A_STAT:  rd_byte = status_byte(irq_flag, valid_flag);
            A_C0L:   rd_byte = ch0_data[7:0];
            A_C0H:   rd_byte = shadow0;
            A_C1L:   rd_byte = ch1_data[7:0];
            A_C1H:   rd_byte = shadow1;
            default: ;
        endcase
    end

    assert_clr_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        irq_clear_o |=> !irq_clear_o);

    assert_ptr_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_pulse && auto_mode) |=> (ptr == $past(ptr + 5'd1)));

    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((rd_pulse || data_wr) && !auto_mode) |=> $stable(ptr));

    assert_shadow_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_pulse && ptr == A_C0L) |=> (shadow0 == $past(ch0_data[15:8])));

endmodule

// File: rtl/lux_reg_target.sv
module lux_reg_target #(
    parameter logic [6:0] TARGET_ADDR = 7'h39,
    parameter int         NUM_CFG     = 16,
    parameter logic [7:0] ID_VALUE    = 8'h34,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    input  logic [15:0]            ch0_data_i,
    input  logic [15:0]            ch1_data_i,
    input  logic                   irq_flag_i,
    input  logic                   valid_flag_i,
    output logic                   irq_clear_o,
    output logic [NUM_CFG*8-1:0]   cfg_o
);
    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wr_pulse, wr_first, rd_pulse;
    logic [7:0] wr_byte, rd_byte;

    lux_bus_sense #(.SYNC_STAGES(SYNC_STAGES)) sense_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    lux_byte_engine #(.TARGET_ADDR(TARGET_ADDR)) engine_i (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe_o), .wr_pulse(wr_pulse), .wr_byte(wr_byte),
        .wr_first(wr_first), .rd_pulse(rd_pulse), .rd_byte(rd_byte)
    );

    lux_reg_bank #(.NUM_CFG(NUM_CFG), .ID_VALUE(ID_VALUE)) bank_i (
        .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .wr_byte(wr_byte),
        .wr_first(wr_first), .rd_pulse(rd_pulse), .rd_byte(rd_byte),
        .ch0_data(ch0_data_i), .ch1_data(ch1_data_i),
        .irq_flag(irq_flag_i), .valid_flag(valid_flag_i),
        .cfg_o(cfg_o), .irq_clear_o(irq_clear_o)
    );

endmodule

// File: tb/lux_reg_target_tb.sv
module lux_reg_target_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 8;
    localparam logic [6:0] ADDR = 7'h39;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    logic [15:0] ch0 = '0, ch1 = '0;
    logic irq_f = 1'b0, valid_f = 1'b0;
    logic irq_clr;
    logic [127:0] cfg;
    wire  sda_bus = sda_m & ~sda_oe;

    int checks = 0, failures = 0, clr_cnt = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] mon_byte;
    event       rd_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    lux_reg_target dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .ch0_data_i(ch0), .ch1_data_i(ch1),
        .irq_flag_i(irq_f), .valid_flag_i(valid_f),
        .irq_clear_o(irq_clr), .cfg_o(cfg)
    );

    always @(posedge clk) if (irq_clr) clr_cnt <= clr_cnt + 1;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                chk("scoreboard-empty", 1, 0);
            end else begin
                chk(tag_q.pop_front(), mon_byte, exp_q.pop_front());
            end
        end
    end

    task automatic expect_byte(input string tag, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wait_q(); repeat (Q) @(negedge clk); endtask

    task automatic bit_w(input logic b);
        sda_m = b; wait_q(); scl_m = 1'b1; wait_q(); wait_q(); scl_m = 1'b0; wait_q();
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q(); b = sda_bus; wait_q(); scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_q(); sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
    endtask

    task automatic byte_w(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) bit_w(b[i]);
        bit_r(nack);
    endtask

    task automatic byte_r(input logic last);
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) bit_r(v[i]);
        bit_w(last);
        mon_byte = v;
        -> rd_ev;
    endtask

    // write transaction: all bytes must be acknowledged (R1)
    task automatic wr_txn(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2, input int n);
        logic nk, any;
        any = 1'b0;
        bus_start();
        byte_w({ADDR, 1'b0}, nk); any |= nk;
        byte_w(b0, nk); any |= nk;
        if (n > 1) begin byte_w(b1, nk); any |= nk; end
        if (n > 2) begin byte_w(b2, nk); any |= nk; end
        bus_stop();
        chk("R1 write acks", any, 1'b0);
    endtask

    // combined read: command, repeated start, n reads
    task automatic cmb_rd(input logic [7:0] cmd, input int n);
        logic nk, any;
        any = 1'b0;
        bus_start();
        byte_w({ADDR, 1'b0}, nk); any |= nk;
        byte_w(cmd, nk); any |= nk;
        bus_rstart();
        byte_w({ADDR, 1'b1}, nk); any |= nk;
        for (int i = 0; i < n; i++) byte_r(i == n - 1);
        chk("R10 released after read NACK", sda_oe, 1'b0);
        bus_stop();
        chk("R1 combined acks", any, 1'b0);
    endtask

    // plain read with no command
    task automatic plain_rd(input int n);
        logic nk;
        bus_start();
        byte_w({ADDR, 1'b1}, nk);
        for (int i = 0; i < n; i++) byte_r(i == n - 1);
        bus_stop();
        chk("R6 read address ack", nk, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk("watchdog expired", 1, 0);
        summary();
    end

    initial begin
        logic nk;
        int c0;
        logic [127:0] snap;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset sda released", sda_oe, 1'b0);
        chk("R9 reset cfg zero", cfg, '0);
        chk("R4 reset no clear pulse", clr_cnt, 0);

        // R2 auto-increment command then writes
        wr_txn(8'hA0, 8'h11, 8'h00, 1);
        wr_txn(8'hA0, 8'h11, 8'h22, 3);
        wr_txn(8'hA2, 8'h33, 8'h00, 2);
        chk("R2 R9 cfg byte0", cfg[7:0], 8'h11);
        chk("R2 R3 cfg byte1", cfg[15:8], 8'h22);
        chk("R2 cfg byte2", cfg[23:16], 8'h33);

        // R6 combined read, R3 auto increment
        expect_byte("R6 combined byte0", 8'h11);
        expect_byte("R3 auto byte1", 8'h22);
        expect_byte("R3 auto byte2", 8'h33);
        cmb_rd(8'hA0, 3);

        // R3 repeated mode writes land on one register
        wr_txn(8'h81, 8'h44, 8'h55, 3);
        chk("R3 repeated last write", cfg[15:8], 8'h55);
        chk("R3 repeated neighbour untouched", cfg[23:16], 8'h33);
        expect_byte("R6 no-cmd read", 8'h55);
        expect_byte("R3 repeated read", 8'h55);
        plain_rd(2);

        // R5 first byte with bit 7 clear is data
        wr_txn(8'h3C, 8'h00, 8'h00, 1);
        chk("R5 data at stored pointer", cfg[15:8], 8'h3C);

        // R1 wrong address
        snap = cfg;
        bus_start();
        byte_w({7'h2A, 1'b0}, nk);
        chk("R1 mismatch NACK", nk, 1'b1);
        byte_w(8'h05, nk);
        chk("R1 silent after mismatch", nk, 1'b1);
        bus_stop();
        chk("R1 cfg unchanged", cfg, snap);

        // R4 special functions
        c0 = clr_cnt;
        wr_txn(8'hE6, 8'h00, 8'h00, 1);
        repeat (10) @(negedge clk);
        chk("R4 single clear pulse", clr_cnt, c0 + 1);
        wr_txn(8'hE0, 8'h00, 8'h00, 1);
        wr_txn(8'hC5, 8'h00, 8'h00, 1);
        repeat (10) @(negedge clk);
        chk("R4 no pulse for other codes", clr_cnt, c0 + 1);
        expect_byte("R4 pointer kept", 8'h3C);
        expect_byte("R4 mode kept repeated", 8'h3C);
        plain_rd(2);

        // R8 id and status
        irq_f = 1'b1; valid_f = 1'b1;
        expect_byte("R8 id", 8'h34);
        expect_byte("R8 status both", 8'h11);
        cmb_rd(8'hB2, 2);
        irq_f = 1'b0;
        expect_byte("R8 status valid only", 8'h01);
        cmb_rd(8'h93, 1);

        // R7 shadow
        ch0 = 16'hABCD; ch1 = 16'h5678;
        expect_byte("R7 ch0 low", 8'hCD);
        cmb_rd(8'hB4, 1);
        ch0 = 16'h1234; ch1 = 16'h9A11;
        expect_byte("R7 ch0 high from shadow", 8'hAB);
        cmb_rd(8'h95, 1);
        expect_byte("R7 ch1 low live", 8'h11);
        expect_byte("R7 ch1 high captured", 8'h9A);
        expect_byte("R9 unimplemented 0x18", 8'h00);
        cmb_rd(8'hB6, 3);

        // R9 read-only and unimplemented writes ignored
        snap = cfg;
        wr_txn(8'h93, 8'hFF, 8'h00, 2);
        wr_txn(8'hB0, 8'h77, 8'h66, 3);
        chk("R9 cfg unchanged by high writes", cfg, snap);
        expect_byte("R9 unimplemented 0x10", 8'h00);
        expect_byte("R9 unimplemented 0x11", 8'h00);
        cmb_rd(8'hB0, 2);
        expect_byte("R9 status not written", 8'h01);
        cmb_rd(8'h93, 1);

        // R3 wrap from 0x1F to 0x00
        wr_txn(8'hBF, 8'h66, 8'h99, 3);
        chk("R3 wrap write to 0x00", cfg[7:0], 8'h99);
        expect_byte("R3 wrap read 0x1F", 8'h00);
        expect_byte("R3 wrap read 0x00", 8'h99);
        cmb_rd(8'hBF, 2);

        chk("R10 released after stop", sda_oe, 1'b0);
        repeat (20) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        summary();
    end

endmodule